// File: doc/BRIEF.md
# Frequency Hop Channel Sequencer

This block picks the carrier for every transmit slot of a frequency-hopping control link. It keeps a table of 29 channels for one of two bands. Channels 0 to 26 are evenly spaced from a band base. The two top entries are filled when the block starts, by copying two fixed channels that the hop step selects. A start strobe draws the hop step from a seed value, selects the band and resets the hop position.

Each slot strobe takes the channel at the current hop position and divides its frequency in Hz by 61 in a sequential divider. The result is a 24-bit synthesizer word, given out as three bytes. The block also reports the hop position and step that produced the word, then moves the hop position on by the step, modulo 29. A radio programming sequencer reads the bytes once the valid flag is high.

Top module: `hop_seq_top`

## Requirements
- R1: After reset, `word_valid_o` is 0 and `hop_idx_o`, `hop_step_o` and all three synthesizer bytes are 0.
- R2: On `init_i` the hop step becomes 1 + (`seed_i` mod 24), a value in the range 1 to 24. It shows on `hop_step_o` from the next cycle.
- R3: Fixed channel i (0 to 26) is base + i*499712 Hz. The base is 914472960 Hz when `band_sel_i` is 0 and 859504640 Hz when it is 1. The band is sampled only at `init_i`.
- R4: Table entry 27 holds the frequency of channel step and entry 28 holds the frequency of channel step+1, both in the band chosen at init.
- R5: After `init_i` the hop position is 0. Each accepted slot moves it to (position + step) mod 29, so `hop_idx_o` is always below 29.
- R6: The synthesizer word is floor(frequency / 61) over 24 bits. `syn_msb_o` carries bits 23:16, `syn_mid_o` bits 15:8 and `syn_lsb_o` bits 7:0.
- R7: `hop_idx_o` and `hop_step_o` give the position and step that produced the current word, taken before the position moves on. `word_valid_o` goes low when a slot is accepted and rises only after all three bytes are final. While it stays high, the bytes and the position do not change.
- R8: A slot strobe before the first `init_i` after reset has no effect: `word_valid_o` stays 0 and the hop position does not move.
- R9: A slot strobe that arrives while a division is running, or in its completion cycle, is ignored and does not move the hop position.
- R10: An `init_i` at any time stops a running division, clears `word_valid_o` and restarts the hop position at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| band_sel_i | input | 1 | Band choice sampled at init: 0 high band, 1 low band |
| seed_i | input | 32 | Random value used to draw the hop step at init |
| init_i | input | 1 | Start strobe: draws the step, patches the table, resets the position |
| slot_i | input | 1 | Transmit slot strobe |
| hop_idx_o | output | 5 | Hop position used for the current word |
| hop_step_o | output | 5 | Hop step in use |
| syn_msb_o | output | 8 | Synthesizer word bits 23:16 |
| syn_mid_o | output | 8 | Synthesizer word bits 15:8 |
| syn_lsb_o | output | 8 | Synthesizer word bits 7:0 |
| word_valid_o | output | 1 | All three bytes are ready for the current slot |

## Verification
The bench builds the block with its default parameters: a 29-entry table with 27 fixed channels, steps drawn modulo 24, and a 32-bit dividend divided by 61. With these values it can use seeds that give the smallest step (1) and the largest (24), so the patched entries copy channels from both ends of the fixed range. Thirty slots per start visit every residue modulo 29, because 29 is prime. That makes every table entry, including both patched ones, reach the divider in both bands.

// File: rtl/hop_seq_pkg.sv
package hop_seq_pkg;
  typedef logic [7:0] syn_byte_t;
  localparam int unsigned SYN_BYTES = 3;
endpackage

// File: rtl/hop_step_calc.sv
module hop_step_calc #(
  parameter int unsigned SEED_W   = 32,
  parameter int unsigned STEP_MOD = 24,
  parameter int unsigned STEP_W   = 5
) (
  input  logic [SEED_W-1:0] seed_i,
  output logic [STEP_W-1:0] step_o
);
  // step lies in 1..STEP_MOD
  assign step_o = STEP_W'(seed_i % SEED_W'(STEP_MOD) + SEED_W'(1));
endmodule

// File: rtl/hop_chan_table.sv
module hop_chan_table #(
  parameter int unsigned NUM_CH       = 29,
  parameter int unsigned FIXED_CH     = 27,
  parameter int unsigned FREQ_W       = 32,
  parameter int unsigned IDX_W        = 5,
  parameter int unsigned STEP_W       = 5,
  parameter int unsigned HIGH_BASE_HZ = 914472960,
  parameter int unsigned LOW_BASE_HZ  = 859504640,
  parameter int unsigned SPACING_HZ   = 499712
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              band_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [FREQ_W-1:0] freq_o
);
  localparam int unsigned NUM_PATCH = NUM_CH - FIXED_CH;

  logic              band_q;
  logic [FREQ_W-1:0] patch_q [NUM_PATCH];

  function automatic logic [FREQ_W-1:0] ch_freq(input logic band, input logic [IDX_W-1:0] ch);
    return (band ? FREQ_W'(LOW_BASE_HZ) : FREQ_W'(HIGH_BASE_HZ))
           + FREQ_W'(ch) * FREQ_W'(SPACING_HZ);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) band_q <= 1'b0;
    else if (load_i) band_q <= band_i;
  end

  // patch entry p copies fixed channel step+p
  for (genvar p = 0; p < NUM_PATCH; p++) begin : g_patch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) patch_q[p] <= '0;
      else if (load_i) patch_q[p] <= ch_freq(band_i, IDX_W'(step_i) + IDX_W'(p));
    end
  end

  always_comb begin
    freq_o = ch_freq(band_q, rd_idx_i);
    for (int p = 0; p < NUM_PATCH; p++)
      if (rd_idx_i == IDX_W'(FIXED_CH + p)) freq_o = patch_q[p];
  end
endmodule

// File: rtl/hop_div_seq.sv
module hop_div_seq #(
  parameter int unsigned DVD_W   = 32,
  parameter int unsigned DIVISOR = 61
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [DVD_W-1:0] dividend_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DVD_W-1:0] quot_o
);
  localparam int unsigned REM_W = $clog2(DIVISOR) + 1;
  localparam int unsigned CNT_W = $clog2(DVD_W);

  logic [REM_W-1:0] rem_q, trial, rem_nxt;
  logic [DVD_W-1:0] quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q, qbit;

  // restoring division, one quotient bit per cycle
  assign trial   = {rem_q[REM_W-2:0], quo_q[DVD_W-1]};
  assign qbit    = trial >= REM_W'(DIVISOR);
  assign rem_nxt = qbit ? trial - REM_W'(DIVISOR) : trial;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        rem_q  <= '0;
        quo_q  <= dividend_i;
      end else if (busy_q) begin
        rem_q <= rem_nxt;
        quo_q <= {quo_q[DVD_W-2:0], qbit};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(DVD_W - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quot_o = quo_q;
endmodule

// File: rtl/hop_seq_top.sv
module hop_seq_top
  import hop_seq_pkg::*;
#(
  parameter int unsigned NUM_CH       = 29,
  parameter int unsigned FIXED_CH     = 27,
  parameter int unsigned STEP_MOD     = 24,
  parameter int unsigned SEED_W       = 32,
  parameter int unsigned FREQ_W       = 32,
  parameter int unsigned DIVISOR      = 61,
  parameter int unsigned HIGH_BASE_HZ = 914472960,
  parameter int unsigned LOW_BASE_HZ  = 859504640,
  parameter int unsigned SPACING_HZ   = 499712,
  localparam int unsigned IDX_W       = $clog2(NUM_CH),
  localparam int unsigned STEP_W      = $clog2(STEP_MOD + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              band_sel_i,
  input  logic [SEED_W-1:0] seed_i,
  input  logic              init_i,
  input  logic              slot_i,
  output logic [IDX_W-1:0]  hop_idx_o,
  output logic [STEP_W-1:0] hop_step_o,
  output logic [7:0]        syn_msb_o,
  output logic [7:0]        syn_mid_o,
  output logic [7:0]        syn_lsb_o,
  output logic              word_valid_o
);
  localparam int unsigned WORD_W = 8 * SYN_BYTES;

  logic [STEP_W-1:0] new_step, step_q;
  logic [IDX_W-1:0]  cur_idx_q, nxt_idx;
  logic [IDX_W:0]    idx_sum;
  logic [FREQ_W-1:0] freq;
  logic [FREQ_W-1:0] quot;
  logic [WORD_W-1:0] word_q;
  logic              armed_q, div_busy, div_done, pend, accept;

  hop_step_calc #(.SEED_W(SEED_W), .STEP_MOD(STEP_MOD), .STEP_W(STEP_W)) u_step (
    .seed_i (seed_i),
    .step_o (new_step)
  );

  hop_chan_table #(
    .NUM_CH(NUM_CH), .FIXED_CH(FIXED_CH), .FREQ_W(FREQ_W), .IDX_W(IDX_W), .STEP_W(STEP_W),
    .HIGH_BASE_HZ(HIGH_BASE_HZ), .LOW_BASE_HZ(LOW_BASE_HZ), .SPACING_HZ(SPACING_HZ)
  ) u_tab (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (init_i),
    .band_i   (band_sel_i),
    .step_i   (new_step),
    .rd_idx_i (cur_idx_q),
    .freq_o   (freq)
  );

  hop_div_seq #(.DVD_W(FREQ_W), .DIVISOR(DIVISOR)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept),
    .abort_i    (init_i),
    .dividend_i (freq),
    .busy_o     (div_busy),
    .done_o     (div_done),
    .quot_o     (quot)
  );

  assign pend    = div_busy | div_done;
  assign accept  = slot_i & armed_q & ~pend & ~init_i;
  assign idx_sum = {1'b0, cur_idx_q} + (IDX_W + 1)'(step_q);
  assign nxt_idx = (idx_sum >= (IDX_W + 1)'(NUM_CH)) ? IDX_W'(idx_sum - (IDX_W + 1)'(NUM_CH))
                                                      : idx_sum[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q      <= 1'b0;
      step_q       <= '0;
      cur_idx_q    <= '0;
      hop_idx_o    <= '0;
      hop_step_o   <= '0;
      word_q       <= '0;
      word_valid_o <= 1'b0;
    end else if (init_i) begin
      armed_q      <= 1'b1;
      step_q       <= new_step;
      cur_idx_q    <= '0;
      hop_idx_o    <= '0;
      hop_step_o   <= new_step;
      word_valid_o <= 1'b0;
    end else if (accept) begin
      hop_idx_o    <= cur_idx_q;
      hop_step_o   <= step_q;
      cur_idx_q    <= nxt_idx;
      word_valid_o <= 1'b0;
    end else if (div_done) begin
      word_q       <= quot[WORD_W-1:0];
      word_valid_o <= 1'b1;
    end
  end

  assign syn_msb_o = word_q[23:16];
  assign syn_mid_o = word_q[15:8];
  assign syn_lsb_o = word_q[7:0];
endmodule

// File: rtl/hop_seq_chk.sv
module hop_seq_chk #(
  parameter int unsigned NUM_CH   = 29,
  parameter int unsigned STEP_MOD = 24,
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned STEP_W   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              init_i,
  input logic              slot_i,
  input logic              armed_i,
  input logic              pend_i,
  input logic [IDX_W-1:0]  hop_idx_o,
  input logic [STEP_W-1:0] hop_step_o,
  input logic [7:0]        syn_msb_o,
  input logic [7:0]        syn_mid_o,
  input logic [7:0]        syn_lsb_o,
  input logic              word_valid_o
);
  a_r2_step_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (hop_step_o >= STEP_W'(1) && hop_step_o <= STEP_W'(STEP_MOD)));

  a_r5_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hop_idx_o < IDX_W'(NUM_CH));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o && !init_i && !slot_i) |=>
      (word_valid_o && $stable({syn_msb_o, syn_mid_o, syn_lsb_o}) && $stable(hop_idx_o)));

  a_r7_rise_after_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(word_valid_o) |-> $past(pend_i));

  a_r8_unarmed_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_i && slot_i && !init_i) |=> (!word_valid_o && $stable(hop_idx_o)));

  a_r9_busy_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i && slot_i && !init_i) |=> ($stable(hop_idx_o) && $stable(hop_step_o)));

  a_r10_init_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (!word_valid_o && hop_idx_o == '0));
endmodule

bind hop_seq_top hop_seq_chk #(
  .NUM_CH(NUM_CH), .STEP_MOD(STEP_MOD), .IDX_W(IDX_W), .STEP_W(STEP_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .init_i       (init_i),
  .slot_i       (slot_i),
  .armed_i      (armed_q),
  .pend_i       (pend),
  .hop_idx_o    (hop_idx_o),
  .hop_step_o   (hop_step_o),
  .syn_msb_o    (syn_msb_o),
  .syn_mid_o    (syn_mid_o),
  .syn_lsb_o    (syn_lsb_o),
  .word_valid_o (word_valid_o)
);

// File: tb/hop_seq_top_test.sv
module hop_seq_top_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        band_sel_i = 1'b0;
  logic [31:0] seed_i = '0;
  logic        init_i = 1'b0;
  logic        slot_i = 1'b0;
  logic [4:0]  hop_idx_o, hop_step_o;
  logic [7:0]  syn_msb_o, syn_mid_o, syn_lsb_o;
  logic        word_valid_o;

  int n_cmp = 0;
  int n_err = 0;
  int cyc = 0;
  int exp_idx, exp_step, exp_band;

  // {band, seed}
  localparam logic [32:0] VEC [6] = '{
    {1'b0, 32'd0}, {1'b1, 32'd23}, {1'b0, 32'd47},
    {1'b1, 32'hFFFF_FFFF}, {1'b0, 32'd1000}, {1'b1, 32'd24}
  };

  hop_seq_top uut (.*);

  always #10 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 150000) begin
      n_cmp++; n_err++;
      $display("FAIL watchdog (all reqs) actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_word(input int band, input int idx, input int step);
    int ch;
    longint f;
    ch = (idx < 27) ? idx : ((idx == 27) ? step : step + 1);
    f = (band != 0 ? 64'd859504640 : 64'd914472960) + longint'(ch) * 64'd499712;
    return f / 61;
  endfunction

  task automatic do_init(input logic band, input logic [31:0] seed);
    @(negedge clk_i);
    band_sel_i = band; seed_i = seed; init_i = 1'b1;
    @(negedge clk_i);
    init_i = 1'b0;
    exp_band = band;
    exp_step = 1 + int'(seed % 32'd24);
    exp_idx  = 0;
  endtask

  task automatic pulse_slot();
    @(negedge clk_i); slot_i = 1'b1;
    @(negedge clk_i); slot_i = 1'b0;
  endtask

  task automatic wait_valid();
    int n = 0;
    while (!word_valid_o && n < 100) begin
      @(negedge clk_i); n++;
    end
    check("R7 valid rises", word_valid_o, 1);
  endtask

  task automatic slot_and_check();
    pulse_slot();
    check("R7 valid drops on accept", word_valid_o, 0);
    wait_valid();
    check("R5 hop index", hop_idx_o, exp_idx);
    check("R2 hop step", hop_step_o, exp_step);
    check(exp_idx >= 27 ? "R4 patched word" : "R6 R3 word",
          {syn_msb_o, syn_mid_o, syn_lsb_o}, exp_word(exp_band, exp_idx, exp_step));
    exp_idx = (exp_idx + exp_step) % 29;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 valid", word_valid_o, 0);
    check("R1 idx", hop_idx_o, 0);
    check("R1 step", hop_step_o, 0);
    check("R1 word", {syn_msb_o, syn_mid_o, syn_lsb_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R8 slot before init
    pulse_slot();
    repeat (50) @(negedge clk_i);
    check("R8 valid stays low", word_valid_o, 0);
    check("R8 idx unchanged", hop_idx_o, 0);

    // vector table
    for (int v = 0; v < 6; v++) begin
      do_init(VEC[v][32], VEC[v][31:0]);
      check("R2 step after init", hop_step_o, exp_step);
      for (int s = 0; s < 30; s++) slot_and_check();
    end

    // R3 band sampled only at init
    do_init(1'b0, 32'd5);
    band_sel_i = 1'b1;
    slot_and_check();

    // R9 slot during running division
    pulse_slot();
    repeat (5) @(negedge clk_i);
    pulse_slot();
    wait_valid();
    check("R9 idx of first slot", hop_idx_o, exp_idx);
    exp_idx = (exp_idx + exp_step) % 29;
    slot_and_check();

    // R10 init during division
    pulse_slot();
    repeat (4) @(negedge clk_i);
    do_init(1'b1, 32'd7);
    check("R10 valid cleared", word_valid_o, 0);
    check("R10 idx restart", hop_idx_o, 0);
    repeat (50) @(negedge clk_i);
    check("R10 aborted division stays invalid", word_valid_o, 0);
    slot_and_check();
    slot_and_check();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule